// File: doc/BRIEF.md
# ATA PIO Cycle Sequencer

This block runs the host side of one ATA programmed-I/O register or data transfer at a time. A client places a request on a valid/ready interface. The request carries a direction, a register address, a chip-select pattern, write data and a timing mode from 0 to 4. The sequencer drives the address and active-low chip-select lines, pulses the active-low read or write strobe, and enables the host data driver during writes. On reads it captures the device data, and it lets the device stretch the strobe through its IORDY line. Each interval is counted in cycles of the system clock. At elaboration, each nanosecond minimum is converted to a cycle count by dividing by the clock period and rounding up, and the counts are held in a per-mode lookup.

The cycle walks through a fixed sequence of states:

- `S_IDLE` goes to `S_SETUP` when a request is accepted.
- `S_SETUP` goes to `S_STROBE` when the address-setup count expires.
- `S_STROBE` goes to `S_HOLD` if IORDY is high when the minimum width expires. It goes to `S_WAIT` if IORDY is low at that point.
- `S_WAIT` goes to `S_HOLD` when IORDY is sampled high, or when the wait limit runs out.
- `S_HOLD` goes to `S_RECOVER` when the hold count expires.
- `S_RECOVER` goes to `S_FINISH` once both the whole-cycle minimum and the recovery minimum are met.
- `S_FINISH` pulses `done` and returns to `S_IDLE`.

Top module: `pio_cycle_seq`

## Requirements

- R1: After reset, `req_ready`=1, `ata_rd_n`=1, `ata_wr_n`=1, `ata_cs_n`=all ones, `ata_dd_oe`=0, `done`=0 and `timeout`=0.
- R2: Address and chip-select (`ata_cs_n` = inverse of `req_cs`) are driven for exactly AS cycles before the strobe asserts. AS is 7,5,3,3,3 for modes 0..4 at a 10 ns clock. They do not change on the strobe's falling edge.
- R3: A read asserts only `ata_rd_n`, and a write asserts only `ata_wr_n`. The strobe stays low for at least SW cycles, where SW is 17,13,10,8,7 for modes 0..4. The two strobes are never low together.
- R4: If IORDY is low in the last minimum-width cycle, the strobe stays low through the first later cycle in which IORDY is sampled high, that cycle included.
- R5: If IORDY is still low after 125 extended cycles, the strobe negates and `timeout` rises. `timeout` stays set until the next request is accepted, which clears it.
- R6: After the strobe negates, address and chip-select stay driven for H cycles. For reads H is the address hold (2,2,1,1,1). For writes H is the larger of that and the write-data hold (3,2,2,1,1). Neither changes on the strobe's rising edge.
- R7: The cycle count from the first address cycle to the `done` cycle (exclusive) equals max(CYC, AS + strobe length + max(H+1, REC)). CYC is 60,39,24,18,12 and REC is 0,0,0,7,3 for modes 0..4.
- R8: `ata_dd_oe` is high only in write cycles. It spans the first strobe cycle through the last hold cycle, with `ata_dd_out` equal to the request's write data. It is never high while the read strobe is low.
- R9: On a read, `rd_data` takes the value of `ata_dd_in` in the last strobe-low cycle. It keeps that value until the next read.
- R10: Mode codes 5 to 7 use the mode 4 timing.
- R11: `req_ready` is high only in the idle state. A request is taken when `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse and is followed by `req_ready`=1.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Register address |
| req_cs | input | CS_W | Chip selects to assert (1 = assert) |
| req_wdata | input | DATA_W | Write data |
| req_mode | input | MODE_W | Timing mode, 0..4 (higher codes act as 4) |
| done | output | 1 | One-cycle end-of-cycle pulse |
| timeout | output | 1 | IORDY wait limit was reached in the last cycle |
| rd_data | output | DATA_W | Data captured by the last read |
| ata_addr | output | ADDR_W | Device address lines |
| ata_cs_n | output | CS_W | Device chip selects, active low |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | DATA_W | Host data toward the device |
| ata_dd_oe | output | 1 | Host data driver enable |
| ata_dd_in | input | DATA_W | Device data toward the host |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification

Transfers are issued in every mode code, including 5 to 7, in both directions. IORDY is released after a chosen number of strobe cycles. With no hold-off, the measured widths and the overall length separate the five per-mode count sets. A release just before, at and after the minimum width tells a correctly stretched strobe from an off-by-one. A release beyond the wait limit exposes the timeout path and the clearing of the flag by the next request.

The device data changes every strobe cycle, so a capture taken one cycle early or late shows as a wrong value. Modes 3 and 4, where the recovery minimum rather than the cycle minimum sets the length, show whether recovery is counted from strobe negation.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int NUM_MODES  = 5;
    localparam int PIO_CNT_W  = 8;
    localparam int IORDY_MAX_NS = 1250;

    typedef enum int {
        F_CYC, F_SETUP, F_WIDTH, F_RECOV, F_AHOLD, F_WHOLD
    } tim_field_e;

    typedef struct packed {
        logic [PIO_CNT_W-1:0] cyc;
        logic [PIO_CNT_W-1:0] setup;
        logic [PIO_CNT_W-1:0] width;
        logic [PIO_CNT_W-1:0] recov;
        logic [PIO_CNT_W-1:0] ahold;
        logic [PIO_CNT_W-1:0] whold;
    } pio_tim_t;

    function automatic int ceil_div(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    // Minimum interval in nanoseconds for one field of one mode.
    function automatic int field_ns(input tim_field_e f, input int m);
        int v;
        v = 0;
        unique case (f)
            F_CYC:   case (m) 0: v = 600; 1: v = 383; 2: v = 240; 3: v = 180; default: v = 120; endcase
            F_SETUP: case (m) 0: v = 70;  1: v = 50;  2: v = 30;  3: v = 30;  default: v = 25;  endcase
            F_WIDTH: case (m) 0: v = 165; 1: v = 125; 2: v = 100; 3: v = 80;  default: v = 70;  endcase
            F_RECOV: case (m) 3: v = 70;  4: v = 25;  default: v = 0; endcase
            F_AHOLD: case (m) 0: v = 20;  1: v = 15;  default: v = 10; endcase
            F_WHOLD: case (m) 0: v = 30;  1: v = 20;  2: v = 15;  default: v = 10; endcase
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic logic [PIO_CNT_W-1:0] to_cyc(input int ns, input int per, input bit at_least_one);
        int c;
        c = ceil_div(ns, per);
        if (at_least_one && c < 1) c = 1;
        return PIO_CNT_W'(c);
    endfunction

    function automatic pio_tim_t build_timing(input int m, input int per);
        pio_tim_t t;
        t.cyc   = to_cyc(field_ns(F_CYC,   m), per, 1'b1);
        t.setup = to_cyc(field_ns(F_SETUP, m), per, 1'b1);
        t.width = to_cyc(field_ns(F_WIDTH, m), per, 1'b1);
        t.recov = to_cyc(field_ns(F_RECOV, m), per, 1'b0);
        t.ahold = to_cyc(field_ns(F_AHOLD, m), per, 1'b1);
        t.whold = to_cyc(field_ns(F_WHOLD, m), per, 1'b1);
        return t;
    endfunction

endpackage

// File: rtl/pio_mode_table.sv
module pio_mode_table
    import pio_timing_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int MODE_W        = 3
) (
    input  logic [MODE_W-1:0] mode_sel,
    output pio_tim_t          tim
);
    localparam int TOP_MODE = NUM_MODES - 1;

    pio_tim_t tbl [NUM_MODES];

    for (genvar gi = 0; gi < NUM_MODES; gi++) begin : g_mode
        assign tbl[gi] = build_timing(gi, CLK_PERIOD_NS);
    end

    always_comb begin
        if (int'(mode_sel) > TOP_MODE) tim = tbl[TOP_MODE];
        else                           tim = tbl[int'(mode_sel)];
    end
endmodule

// File: rtl/pio_down_counter.sv
module pio_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pio_up_counter.sv
module pio_up_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (clr)             cnt <= '0;
        else if (cnt != CNT_MAX)  cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_timing_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int ADDR_W        = 3,
    parameter int CS_W          = 2,
    parameter int DATA_W        = 16,
    parameter int MODE_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MODE_W-1:0] req_mode,
    output logic              done,
    output logic              timeout,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ata_addr,
    output logic [CS_W-1:0]   ata_cs_n,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic [DATA_W-1:0] ata_dd_out,
    output logic              ata_dd_oe,
    input  logic [DATA_W-1:0] ata_dd_in,
    input  logic              ata_iordy
);
    localparam int CW      = PIO_CNT_W;
    localparam int TMO_CYC = ceil_div(IORDY_MAX_NS, CLK_PERIOD_NS);
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_STROBE, S_WAIT, S_HOLD, S_RECOVER, S_FINISH
    } seq_state_e;

    seq_state_e state_q, state_d;

    // Latched request
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   cs_q;
    logic [DATA_W-1:0] wdata_q;
    logic [MODE_W-1:0] mode_q;
    logic              tmo_q;
    logic [DATA_W-1:0] rdata_q;

    // Timing lookup: in idle the incoming mode, otherwise the latched one
    logic [MODE_W-1:0] mode_sel;
    pio_tim_t          tim;

    assign mode_sel = (state_q == S_IDLE) ? req_mode : mode_q;

    pio_mode_table #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .MODE_W        (MODE_W)
    ) u_table (
        .mode_sel (mode_sel),
        .tim      (tim)
    );

    // Counters
    logic          ph_load;
    logic [CW-1:0] ph_val;
    logic [CW-1:0] ph_cnt;
    logic          ph_zero;
    logic          el_clr, rec_clr, wt_clr;
    logic [CW-1:0] el_cnt, rec_cnt, wt_cnt;

    pio_down_counter #(.W(CW)) u_phase (
        .clk (clk), .rst_n (rst_n), .load (ph_load), .load_val (ph_val),
        .cnt (ph_cnt), .zero (ph_zero)
    );

    pio_up_counter #(.W(CW)) u_elapsed (
        .clk (clk), .rst_n (rst_n), .clr (el_clr), .cnt (el_cnt)
    );

    pio_up_counter #(.W(CW)) u_recov (
        .clk (clk), .rst_n (rst_n), .clr (rec_clr), .cnt (rec_cnt)
    );

    pio_up_counter #(.W(CW)) u_wait (
        .clk (clk), .rst_n (rst_n), .clr (wt_clr), .cnt (wt_cnt)
    );

    // Derived timing terms
    logic [CW-1:0] hold_len;
    logic          span_met, recov_met;
    logic          accept, strobe_end, tmo_hit;

    assign hold_len  = (wr_q && (tim.whold > tim.ahold)) ? tim.whold : tim.ahold;
    assign span_met  = ({1'b0, el_cnt}  + (CW+1)'(1)) >= {1'b0, tim.cyc};
    assign recov_met = ({1'b0, rec_cnt} + (CW+1)'(1)) >= {1'b0, tim.recov};
    assign accept    = (state_q == S_IDLE) && req_valid;

    // Next state and counter control
    always_comb begin
        state_d    = state_q;
        ph_load    = 1'b0;
        ph_val     = '0;
        el_clr     = 1'b0;
        rec_clr    = 1'b0;
        wt_clr     = 1'b0;
        strobe_end = 1'b0;
        tmo_hit    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_d = S_SETUP;
                    ph_load = 1'b1;
                    ph_val  = tim.setup - CW'(1);
                    el_clr  = 1'b1;
                end
            end
            S_SETUP: begin
                if (ph_zero) begin
                    state_d = S_STROBE;
                    ph_load = 1'b1;
                    ph_val  = tim.width - CW'(1);
                end
            end
            S_STROBE: begin
                if (ph_zero) begin
                    if (ata_iordy) begin
                        state_d    = S_HOLD;
                        ph_load    = 1'b1;
                        ph_val     = hold_len - CW'(1);
                        rec_clr    = 1'b1;
                        strobe_end = 1'b1;
                    end else begin
                        state_d = S_WAIT;
                        wt_clr  = 1'b1;
                    end
                end
            end
            S_WAIT: begin
                if (ata_iordy || (wt_cnt == TMO_LAST)) begin
                    state_d    = S_HOLD;
                    ph_load    = 1'b1;
                    ph_val     = hold_len - CW'(1);
                    rec_clr    = 1'b1;
                    strobe_end = 1'b1;
                    tmo_hit    = !ata_iordy;
                end
            end
            S_HOLD: begin
                if (ph_zero) state_d = S_RECOVER;
            end
            S_RECOVER: begin
                if (span_met && recov_met) state_d = S_FINISH;
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, read capture and wait-limit flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            cs_q    <= '0;
            wdata_q <= '0;
            mode_q  <= '0;
            tmo_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                cs_q    <= req_cs;
                wdata_q <= req_wdata;
                mode_q  <= req_mode;
                tmo_q   <= 1'b0;
            end
            if (tmo_hit) tmo_q <= 1'b1;
            if (strobe_end && !wr_q) rdata_q <= ata_dd_in;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        done       = 1'b0;
        ata_addr   = '0;
        ata_cs_n   = '1;
        ata_rd_n   = 1'b1;
        ata_wr_n   = 1'b1;
        ata_dd_oe  = 1'b0;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_SETUP: begin
                ata_addr = addr_q;
                ata_cs_n = ~cs_q;
            end
            S_STROBE, S_WAIT: begin
                ata_addr  = addr_q;
                ata_cs_n  = ~cs_q;
                ata_rd_n  = wr_q;
                ata_wr_n  = !wr_q;
                ata_dd_oe = wr_q;
            end
            S_HOLD: begin
                ata_addr  = addr_q;
                ata_cs_n  = ~cs_q;
                ata_dd_oe = wr_q;
            end
            S_RECOVER: ;
            S_FINISH:  done = 1'b1;
            default: ;
        endcase
    end

    assign ata_dd_out = wdata_q;
    assign timeout    = tmo_q;
    assign rd_data    = rdata_q;

endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk #(
    parameter int ADDR_W = 3,
    parameter int CS_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              timeout,
    input logic [ADDR_W-1:0] ata_addr,
    input logic [CS_W-1:0]   ata_cs_n,
    input logic              ata_rd_n,
    input logic              ata_wr_n,
    input logic              ata_dd_oe
);
    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    // R8
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_rd_n |-> !ata_dd_oe);

    // R2
    addr_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ata_rd_n) || $fell(ata_wr_n)) |->
            ($past(ata_rd_n && ata_wr_n) && $stable(ata_addr) && $stable(ata_cs_n)));

    // R6
    addr_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ata_rd_n) || $rose(ata_wr_n)) |-> ($stable(ata_addr) && $stable(ata_cs_n)));

    // R5
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !(req_valid && req_ready)) |=> timeout);

    // R5
    timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !timeout);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n || done) |-> !req_ready);
endmodule

bind pio_cycle_seq pio_cycle_seq_chk #(.ADDR_W(ADDR_W), .CS_W(CS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .timeout   (timeout),
    .ata_addr  (ata_addr),
    .ata_cs_n  (ata_cs_n),
    .ata_rd_n  (ata_rd_n),
    .ata_wr_n  (ata_wr_n),
    .ata_dd_oe (ata_dd_oe)
);

// File: tb/pio_cycle_seq_tb.sv
module pio_cycle_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [1:0]  req_cs = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  req_mode = '0;
    logic        done, timeout;
    logic [15:0] rd_data;
    logic [2:0]  ata_addr;
    logic [1:0]  ata_cs_n;
    logic        ata_rd_n, ata_wr_n, ata_dd_oe;
    logic [15:0] ata_dd_out;
    logic [15:0] ata_dd_in = '0;
    logic        ata_iordy = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [15:0] last_rd = '0;

    localparam int PER = 10;
    localparam int TMO = 125;

    always #10 clk = ~clk;

    pio_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_cs(req_cs),
        .req_wdata(req_wdata), .req_mode(req_mode), .done(done), .timeout(timeout),
        .rd_data(rd_data), .ata_addr(ata_addr), .ata_cs_n(ata_cs_n),
        .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dd_out(ata_dd_out),
        .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
    );

    function automatic int cdiv(input int ns);
        return (ns + PER - 1) / PER;
    endfunction
    function automatic int eff(input int m);
        return (m > 4) ? 4 : m;
    endfunction
    function automatic int t_cyc(input int m);
        int ns[5] = '{600, 383, 240, 180, 120}; return cdiv(ns[eff(m)]);
    endfunction
    function automatic int t_as(input int m);
        int ns[5] = '{70, 50, 30, 30, 25}; return cdiv(ns[eff(m)]);
    endfunction
    function automatic int t_sw(input int m);
        int ns[5] = '{165, 125, 100, 80, 70}; return cdiv(ns[eff(m)]);
    endfunction
    function automatic int t_rec(input int m);
        int ns[5] = '{0, 0, 0, 70, 25}; return cdiv(ns[eff(m)]);
    endfunction
    function automatic int t_hold(input int m, input bit wr);
        int ah[5] = '{20, 15, 10, 10, 10};
        int wh[5] = '{30, 20, 15, 10, 10};
        int a, w;
        a = cdiv(ah[eff(m)]); w = cdiv(wh[eff(m)]);
        return (wr && w > a) ? w : a;
    endfunction
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input int mode, input int rel,
                           input logic [2:0] addr, input logic [1:0] cs, input logic [15:0] wd);
        int setup_c, strobe_c, hold_c, oe_c, span, bad_addr, bad_strb, bad_dout;
        int len, hold, exp_span;
        bit tmo_exp, got_done;
        logic [15:0] pat;
        setup_c = 0; strobe_c = 0; hold_c = 0; oe_c = 0; span = 0;
        bad_addr = 0; bad_strb = 0; bad_dout = 0; got_done = 0;
        pat = 16'(32'h3C00 + mode * 256 + rel);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mode = 3'(mode);
        req_addr = addr; req_cs = cs; req_wdata = wd;
        ata_iordy = (rel == 0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R5: accepted request clears the flag; R11: busy after accept
        chk(timeout == 1'b0, "R5", "timeout after accept", timeout, 0);
        chk(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
        for (int i = 0; i < 600; i++) begin
            if (i > 0) @(negedge clk);
            if (done) begin got_done = 1; break; end
            span++;
            if (ata_dd_oe) begin
                oe_c++;
                if (ata_dd_out != wd) bad_dout++;
            end
            if (!ata_rd_n || !ata_wr_n) begin
                strobe_c++;
                if ((wr && ata_wr_n) || (!wr && ata_rd_n)) bad_strb++;
                if (ata_addr != addr || ata_cs_n != ~cs) bad_addr++;
                ata_iordy = (strobe_c > rel);
                ata_dd_in = pat + 16'(strobe_c);
            end else if (ata_cs_n != 2'b11) begin
                if (ata_addr != addr || ata_cs_n != ~cs) bad_addr++;
                if (strobe_c == 0) setup_c++; else hold_c++;
                if (strobe_c > 0) begin ata_iordy = 1'b1; ata_dd_in = 16'hBAD0; end
            end else begin
                ata_iordy = 1'b1; ata_dd_in = 16'hBAD1;
            end
        end
        chk(got_done, "R11", "done seen", got_done, 1);
        len     = (rel < t_sw(mode)) ? t_sw(mode) : ((rel + 1 < t_sw(mode) + TMO) ? rel + 1 : t_sw(mode) + TMO);
        tmo_exp = (rel >= t_sw(mode) + TMO);
        hold    = t_hold(mode, wr);
        exp_span = max2(t_cyc(mode), t_as(mode) + len + max2(hold + 1, t_rec(mode)));
        chk(setup_c == t_as(mode), "R2", "setup cycles", setup_c, t_as(mode));
        chk(bad_addr == 0, "R2", "addr/cs mismatch cycles", bad_addr, 0);
        chk(bad_strb == 0, "R3", "wrong strobe cycles", bad_strb, 0);
        if (rel < t_sw(mode)) chk(strobe_c == len, "R3", "strobe width", strobe_c, len);
        else chk(strobe_c == len, "R4", "stretched strobe width", strobe_c, len);
        chk(timeout == tmo_exp, "R5", "timeout flag", timeout, int'(tmo_exp));
        chk(hold_c == hold, "R6", "hold cycles", hold_c, hold);
        chk(span == exp_span, "R7", "cycle span", span, exp_span);
        chk(oe_c == (wr ? len + hold : 0), "R8", "oe cycles", oe_c, wr ? len + hold : 0);
        chk(bad_dout == 0, "R8", "write data mismatch cycles", bad_dout, 0);
        if (!wr) last_rd = pat + 16'(len);
        chk(rd_data == last_rd, "R9", "read data", rd_data, last_rd);
        if (mode > 4) chk(span == exp_span, "R10", "clamped mode span", span, exp_span);
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R11", "ready after done", req_ready, 1);
        chk(timeout == tmo_exp, "R5", "timeout held", timeout, int'(tmo_exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0A7A);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(ata_rd_n && ata_wr_n, "R1", "strobes idle high", {ata_rd_n, ata_wr_n}, 3);
        chk(ata_cs_n == 2'b11, "R1", "cs_n idle", ata_cs_n, 3);
        chk(!ata_dd_oe && !done && !timeout, "R1", "oe/done/timeout", {ata_dd_oe, done, timeout}, 0);

        // Directed: each mode both directions, no hold-off (R3, R7)
        for (int m = 0; m < 5; m++) begin
            run_txn(1'b0, m, 0, 3'(m), 2'b01, 16'h1000 + 16'(m));
            run_txn(1'b1, m, 0, 3'(7 - m), 2'b10, 16'hA500 + 16'(m));
        end
        // R4: release around the minimum width
        run_txn(1'b0, 2, t_sw(2) - 1, 3'd1, 2'b01, 16'h0);
        run_txn(1'b0, 2, t_sw(2), 3'd2, 2'b01, 16'h0);
        run_txn(1'b1, 4, t_sw(4) + 9, 3'd3, 2'b11, 16'h5A5A);
        // R5: wait limit, then cleared by the next request
        run_txn(1'b0, 0, t_sw(0) + TMO, 3'd4, 2'b01, 16'h0);
        run_txn(1'b1, 3, t_sw(3) + TMO + 20, 3'd5, 2'b10, 16'h7E7E);
        run_txn(1'b0, 3, 0, 3'd6, 2'b01, 16'h0);
        // R10: codes above 4
        run_txn(1'b0, 5, 0, 3'd0, 2'b01, 16'h0);
        run_txn(1'b1, 7, 3, 3'd7, 2'b10, 16'hC3C3);

        // Constrained random
        for (int n = 0; n < 40; n++) begin
            bit wr;
            int m, rel, sel;
            wr  = 1'($urandom % 2);
            m   = int'($urandom % 8);
            sel = int'($urandom % 4);
            if (sel == 0)      rel = 0;
            else if (sel == 1) rel = int'($urandom % 20);
            else if (sel == 2) rel = t_sw(m) + int'($urandom % 40);
            else               rel = t_sw(m) + TMO - 2 + int'($urandom % 4);
            run_txn(wr, m, rel, 3'($urandom), 2'(1 + $urandom % 3), 16'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule